// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block moves the bits of an 8-bit or 16-bit operand left or right by a count. The operations are plain rotates, rotates that pass through the carry as an extra bit, a logical shift left with two interchangeable codes, a logical shift right and an arithmetic shift right. The count is either the constant one or the value of an 8-bit count input. A start strobe loads the operand, the carry-in and the count. The unit then performs one single-bit step per clock. When the last step is done it raises `done_o` for one cycle, and at that point the result, the carry and the overflow outputs hold the final values.

The unit is meant to sit behind an instruction decoder. The decoder gives the operation code, selects the width, and either asks for a count of one or passes the count register. It then waits for `done_o` and writes the result and the two flags back. While an operation is running, the unit ignores new start strobes.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 (rotate left) moves the top bit of the selected width into the bottom bit on each step, and also into the carry.
- R2: Operation code 1 (rotate right) moves the bottom bit into the top bit of the selected width on each step, and also into the carry.
- R3: Operation codes 2 and 3 rotate left and right through the carry. On each step the carry receives the bit moved out, and the old carry enters the vacated end. This makes the rotate one bit wider than the operand.
- R4: Operation codes 4 and 6 are the same left shift: a zero enters the bottom bit and the top bit goes to the carry.
- R5: Operation code 5 (logical right shift) puts a zero in the top bit and sends the bottom bit to the carry.
- R6: Operation code 7 (arithmetic right shift) keeps the top bit unchanged on each step and sends the bottom bit to the carry.
- R7: After a multi-step operation, the carry holds exactly the last bit moved out. A shift whose count is larger than the width therefore ends with carry 0 and result 0 for left shifts and logical right shifts, and with all bits equal to the sign for arithmetic right shifts.
- R8: When `use_reg_i` is 0 the count is 1, whatever `cnt_reg_i` holds. When `use_reg_i` is 1 the count is `cnt_reg_i`.
- R9: A count of zero returns the operand unchanged, sets the carry to `carry_i`, keeps the previous overflow, and raises `done_o` after one clock.
- R10: For a count of one, the overflow is set as follows. Left operations: new top bit XOR new carry. Logical right shift: the original top bit. Arithmetic right shift: 0. Right rotates: XOR of the two highest result bits. For any other count the overflow keeps its previous value.
- R11: `done_o` is high for exactly one cycle. It rises max(N,1) clock edges after the edge that accepts the start, where N is the count.
- R12: A start strobe that arrives while an operation is in progress has no effect on that operation or on its result.
- R13: With `wide_i` = 0 only bits 7..0 of the operand are used, and bits 15..8 of the result are zero.
- R14: After reset, the result, carry, overflow and done outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | 3 | Operation code (see R1 to R6) |
| wide_i | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| use_reg_i | input | 1 | 1 = count from cnt_reg_i, 0 = count of one |
| cnt_reg_i | input | 8 | Count register value |
| operand_i | input | 16 | Operand |
| carry_i | input | 1 | Carry flag before the operation |
| result_o | output | 16 | Working value, final once done_o is high |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Overflow flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start strobe that arrives in the middle of a multi-step operation. It only shows up if the strobe falls on a cycle when the unit is busy, and it carries an operation code and an operand that would give a visibly different result. The bench starts a four-step rotate, raises start again with a conflicting request one cycle later, and then checks the final value, the done timing and that no second done follows. Counts larger than the width, and counts of exactly the extended rotate length, are driven through the count register. They check that the carry holds the last bit out and not an earlier one.

// File: rtl/shrot_pkg.sv
// Package: shared operation codes and controller states for the shift unit.
// Assumes: operation codes are fixed by the decoder that drives op_i.
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_ROR = 3'd1,
        OP_RCL = 3'd2,
        OP_RCR = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_SAL = 3'd6,
        OP_SAR = 3'd7
    } sr_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sr_state_e;

    // True for the operations that move bits toward the top.
    function automatic logic op_is_left(input sr_op_e op);
        return (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL) || (op == OP_SAL);
    endfunction

endpackage

// File: rtl/shrot_step.sv
// Module: one single-bit step of any shift or rotate on a W-bit value.
// Purely combinational. Also gives the overflow that a one-step operation
// would produce. Assumes W >= 2.
module shrot_step
    import shrot_pkg::*;
#(
    parameter int W = 16
) (
    input  sr_op_e         op_i,
    input  logic [W-1:0]   val_i,
    input  logic           cin_i,
    output logic [W-1:0]   val_o,
    output logic           cout_o,
    output logic           ovf_o
);

    // Next value and bit moved out, chosen by operation.
    always_comb begin
        unique case (op_i)
            OP_ROL:         begin val_o = {val_i[W-2:0], val_i[W-1]}; cout_o = val_i[W-1]; end
            OP_ROR:         begin val_o = {val_i[0], val_i[W-1:1]};   cout_o = val_i[0];   end
            OP_RCL:         begin val_o = {val_i[W-2:0], cin_i};      cout_o = val_i[W-1]; end
            OP_RCR:         begin val_o = {cin_i, val_i[W-1:1]};      cout_o = val_i[0];   end
            OP_SHL, OP_SAL: begin val_o = {val_i[W-2:0], 1'b0};       cout_o = val_i[W-1]; end
            OP_SHR:         begin val_o = {1'b0, val_i[W-1:1]};       cout_o = val_i[0];   end
            default:        begin val_o = {val_i[W-1], val_i[W-1:1]}; cout_o = val_i[0];   end
        endcase
    end

    // Overflow rule for a one-step operation.
    always_comb begin
        if (op_is_left(op_i))    ovf_o = val_o[W-1] ^ cout_o;
        else if (op_i == OP_SHR) ovf_o = val_i[W-1];
        else if (op_i == OP_SAR) ovf_o = 1'b0;
        else                     ovf_o = val_o[W-1] ^ val_o[W-2];
    end

endmodule

// File: rtl/shrot_ctrl.sv
// Module: step sequencer. It accepts a start when idle, counts the steps down
// and pulses done one cycle after the last step (or after one cycle for a
// zero count). Assumes the count is sampled only in the accepting cycle.
module shrot_ctrl
    import shrot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             load_o,
    output logic             step_o,
    output logic             busy_o,
    output logic             done_o
);

    sr_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    // Decode handshake strobes from the state.
    assign busy_o = (state_q == ST_RUN);
    assign load_o = start_i && !busy_o;
    assign step_o = busy_o && (cnt_q != '0);
    assign last   = busy_o && (cnt_q <= CNT_W'(1));

    // State, remaining count and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                cnt_q   <= cnt_i;
                state_q <= ST_RUN;
            end else if (busy_o) begin
                if (step_o) cnt_q <= cnt_q - 1'b1;
                if (last) begin
                    state_q <= ST_IDLE;
                    done_o  <= 1'b1;
                end
            end
        end
    end

    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: the last step is followed by done and a return to idle
    a_r11_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (done_o && !busy_o));

    // R12: a start while busy does not reload the count
    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && cnt_q > CNT_W'(1)) |=> (busy_o && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/shrot_unit.sv
// Module: top of the shift and rotate unit. It holds the working value and
// the flags, and selects between a byte lane and a word lane built from
// shrot_step. The sequencing comes from shrot_ctrl. Assumes DATA_W is even.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic              wide_i,
    input  logic              use_reg_i,
    input  logic [CNT_W-1:0]  cnt_reg_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              done_o
);

    localparam int LANES  = 2;
    localparam int HALF_W = DATA_W / 2;

    sr_op_e            op_q;
    logic              wide_q;
    logic              single_q;
    logic [DATA_W-1:0] work_q;
    logic              cf_q;
    logic              of_q;

    logic              load_en, step_en, busy;
    logic [CNT_W-1:0]  eff_cnt;
    logic [DATA_W-1:0] load_val;

    logic [DATA_W-1:0] lane_val [LANES];
    logic              lane_cf  [LANES];
    logic              lane_of  [LANES];

    // Select the step count and mask the operand to the chosen width.
    always_comb begin
        eff_cnt  = use_reg_i ? cnt_reg_i : CNT_W'(1);
        load_val = operand_i;
        if (!wide_i) load_val[DATA_W-1:HALF_W] = '0;
    end

    shrot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .cnt_i   (eff_cnt),
        .load_o  (load_en),
        .step_o  (step_en),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    // One step lane per width: lane 0 is the byte lane, lane 1 the word lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF_W : DATA_W;
        logic [LW-1:0] nv;
        logic          nc, no;

        shrot_step #(.W(LW)) u_step (
            .op_i   (op_q),
            .val_i  (work_q[LW-1:0]),
            .cin_i  (cf_q),
            .val_o  (nv),
            .cout_o (nc),
            .ovf_o  (no)
        );

        // Zero-extend the lane result to the full width.
        always_comb begin
            lane_val[g]         = '0;
            lane_val[g][LW-1:0] = nv;
        end
        assign lane_cf[g] = nc;
        assign lane_of[g] = no;
    end

    // Operation registers: captured at start, advanced on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_ROL;
            wide_q   <= 1'b0;
            single_q <= 1'b0;
            work_q   <= '0;
            cf_q     <= 1'b0;
            of_q     <= 1'b0;
        end else if (load_en) begin
            op_q     <= sr_op_e'(op_i);
            wide_q   <= wide_i;
            single_q <= (eff_cnt == CNT_W'(1));
            work_q   <= load_val;
            cf_q     <= carry_i;
        end else if (step_en) begin
            work_q <= lane_val[wide_q];
            cf_q   <= lane_cf[wide_q];
            if (single_q) of_q <= lane_of[wide_q];
        end
    end

    assign result_o = work_q;
    assign carry_o  = cf_q;
    assign ovf_o    = of_q;

    // R1: after a rotate-left step the wrapped bit is both bit 0 and the carry
    a_r1_rol_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_q == OP_ROL) |=> (result_o[0] == carry_o));

    // R3: after a rotate-left through carry, bit 0 is the previous carry
    a_r3_rcl_carry_in: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_q == OP_RCL) |=> (result_o[0] == $past(cf_q)));

    // R6: the arithmetic right shift keeps the word sign bit
    a_r6_sar_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_q == OP_SAR && wide_q) |=> (result_o[DATA_W-1] == $past(work_q[DATA_W-1])));

    // R9: a zero count gives back the operand and carry-in, then done
    a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && eff_cnt == '0) |-> ##2 (done_o && result_o == $past(load_val, 2)
                                            && carry_o == $past(carry_i, 2)));

    // R13: byte mode leaves the upper half of the result at zero
    a_r13_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |-> (result_o[DATA_W-1:HALF_W] == '0));

    // R12: no reload of the working value while busy
    a_r12_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_en) |=> $stable(result_o));

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

    typedef struct packed {
        logic [2:0]  op;
        logic        wide;
        logic        ureg;
        logic [7:0]  cnt;
        logic [15:0] opnd;
        logic        cin;
        logic [15:0] res;
        logic        c;
        logic        of;
        logic        chk_of;
        logic [3:0]  tag;
    } vec_t;

    // op, wide, use_reg, count, operand, carry-in | result, carry, ovf, check ovf, requirement
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        {3'd0,1'b1,1'b0,8'd1 ,16'h8001,1'b0, 16'h0003,1'b1,1'b1,1'b1, 4'd1 }, // R1 R10
        {3'd0,1'b0,1'b1,8'd4 ,16'hAB96,1'b0, 16'h0069,1'b1,1'b0,1'b0, 4'd13}, // R13 R1
        {3'd1,1'b1,1'b1,8'd3 ,16'h0005,1'b1, 16'hA000,1'b1,1'b0,1'b0, 4'd2 }, // R2
        {3'd1,1'b0,1'b0,8'd1 ,16'h0001,1'b0, 16'h0080,1'b1,1'b1,1'b1, 4'd2 }, // R2 R10
        {3'd2,1'b0,1'b0,8'd1 ,16'h0080,1'b1, 16'h0001,1'b1,1'b1,1'b1, 4'd3 }, // R3
        {3'd2,1'b0,1'b1,8'd9 ,16'h005A,1'b0, 16'h005A,1'b0,1'b0,1'b0, 4'd3 }, // R3 full loop
        {3'd3,1'b1,1'b1,8'd2 ,16'h0003,1'b0, 16'h8000,1'b1,1'b0,1'b0, 4'd3 }, // R3
        {3'd4,1'b1,1'b0,8'd1 ,16'h4000,1'b1, 16'h8000,1'b0,1'b1,1'b1, 4'd10}, // R10 R4
        {3'd6,1'b1,1'b1,8'd3 ,16'h6001,1'b0, 16'h0008,1'b1,1'b0,1'b0, 4'd4 }, // R4
        {3'd4,1'b0,1'b1,8'd10,16'h00FF,1'b1, 16'h0000,1'b0,1'b0,1'b0, 4'd7 }, // R7
        {3'd5,1'b1,1'b0,8'd1 ,16'h8001,1'b0, 16'h4000,1'b1,1'b1,1'b1, 4'd5 }, // R5 R10
        {3'd5,1'b0,1'b1,8'd3 ,16'h002D,1'b0, 16'h0005,1'b1,1'b0,1'b0, 4'd5 }, // R5
        {3'd7,1'b0,1'b1,8'd2 ,16'h0084,1'b0, 16'h00E1,1'b0,1'b0,1'b0, 4'd6 }, // R6
        {3'd7,1'b1,1'b0,8'd1 ,16'h8003,1'b0, 16'hC001,1'b1,1'b0,1'b1, 4'd6 }, // R6 R10
        {3'd7,1'b1,1'b1,8'd20,16'h8000,1'b0, 16'hFFFF,1'b1,1'b0,1'b0, 4'd7 }, // R7
        {3'd0,1'b1,1'b1,8'd0 ,16'h1234,1'b1, 16'h1234,1'b1,1'b0,1'b0, 4'd9 }  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic        use_reg_i = 1'b0;
    logic [7:0]  cnt_reg_i = '0;
    logic [15:0] operand_i = '0;
    logic        carry_i = 1'b0;
    logic [15:0] result_o;
    logic        carry_o, ovf_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    shrot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wide_i(wide_i),
        .use_reg_i(use_reg_i), .cnt_reg_i(cnt_reg_i), .operand_i(operand_i),
        .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o), .ovf_o(ovf_o),
        .done_o(done_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic wide, input logic ureg,
                         input logic [7:0] cnt, input logic [15:0] opnd, input logic cin);
        op_i = op; wide_i = wide; use_reg_i = ureg; cnt_reg_i = cnt;
        operand_i = opnd; carry_i = cin;
    endtask

    // Issue one operation and wait at a falling edge until done is seen.
    task automatic run_op(input logic [2:0] op, input logic wide, input logic ureg,
                          input logic [7:0] cnt, input logic [15:0] opnd, input logic cin,
                          output logic seen);
        @(negedge clk);
        drive(op, wide, ureg, cnt, opnd, cin);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 400 && !seen; k++) begin
            if (done_o) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14: reset state
        chk("R14", "result", 32'(result_o), 32'h0);
        chk("R14", "carry",  32'(carry_o),  32'h0);
        chk("R14", "ovf",    32'(ovf_o),    32'h0);
        chk("R14", "done",   32'(done_o),   32'h0);

        // Table of vectors.
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].op, VEC[i].wide, VEC[i].ureg, VEC[i].cnt, VEC[i].opnd, VEC[i].cin, seen);
            chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec%0d done", i), 32'(seen), 32'h1);
            chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec%0d result", i), 32'(result_o), 32'(VEC[i].res));
            chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec%0d carry", i), 32'(carry_o), 32'(VEC[i].c));
            if (VEC[i].chk_of)
                chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec%0d ovf", i), 32'(ovf_o), 32'(VEC[i].of));
        end

        // R8: the count register is ignored when the count of one is selected.
        run_op(3'd4, 1'b1, 1'b0, 8'd7, 16'h0001, 1'b0, seen);
        chk("R8", "fixed count result", 32'(result_o), 32'h0002);

        // R9: zero count keeps the overflow from the previous single step.
        run_op(3'd4, 1'b1, 1'b0, 8'd1, 16'h4000, 1'b0, seen);
        chk("R10", "ovf set", 32'(ovf_o), 32'h1);
        @(negedge clk);
        drive(3'd5, 1'b1, 1'b1, 8'd0, 16'h0000, 1'b0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "done not yet", 32'(done_o), 32'h0);
        @(negedge clk);
        chk("R9", "done after one edge", 32'(done_o), 32'h1);
        chk("R9", "ovf held", 32'(ovf_o), 32'h1);
        chk("R9", "result", 32'(result_o), 32'h0);

        // R10: a multi-step operation does not change the overflow.
        run_op(3'd5, 1'b1, 1'b1, 8'd2, 16'h8000, 1'b0, seen);
        chk("R10", "ovf held on multi-step", 32'(ovf_o), 32'h1);

        // R11: done timing for a count of five.
        @(negedge clk);
        drive(3'd0, 1'b1, 1'b1, 8'd5, 16'h0001, 1'b0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk("R11", $sformatf("done after edge %0d", k), 32'(done_o), 32'(k == 5));
        end

        // R12: a second start during a four-step rotate is ignored.
        @(negedge clk);
        drive(3'd0, 1'b1, 1'b1, 8'd4, 16'h0001, 1'b0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        drive(3'd5, 1'b1, 1'b1, 8'd0, 16'hFFFF, 1'b1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R12", "no early done", 32'(done_o), 32'h0);
        @(negedge clk);
        chk("R12", "done", 32'(done_o), 32'h1);
        chk("R12", "result", 32'(result_o), 32'h0010);
        chk("R12", "carry", 32'(carry_o), 32'h0);
        @(negedge clk);
        chk("R12", "no second done", 32'(done_o), 32'h0);
        @(negedge clk);
        chk("R12", "still no done", 32'(done_o), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule